// File: doc/BRIEF.md
# Translation Cache with Dirty-Flag Write Assist

This block is a small fully associative cache of page translations for a flat, single-level page table that holds one entry word per virtual page. A requester presents a virtual address with a read or write flag. The block returns either the physical address or a fault flag together with the faulting virtual page number. On a miss, the block reads the table entry through a single-word memory port. Cached entries stay in place, even after the table in memory changes, until software drops one entry or flushes the whole cache through the invalidate inputs.

Writes receive special handling. A write that hits an entry already marked dirty is completed from the cached copy and does not touch memory, even if the entry in memory has since lost its present or writable permission. A write that hits a clean entry does not trust the cache. The block re-reads the entry from memory and checks the permissions again. It then either faults, or writes the entry back with the dirty flag set and marks the cached copy dirty before it answers.

Top module: `xlat_cache`

## Requirements
- R1: A table entry word carries the present flag at bit 0, the writable flag at bit 1, the dirty flag at bit 6 and the frame number in bits PA_W-1 down to 12. The physical address returned is the frame number joined with the 12-bit page offset of the request.
- R2: A read that misses fetches the entry (one memory read). If that entry is present, the block fills a slot with its frame, writable and dirty flags. A later read of the same page then answers from the cache with no memory access.
- R3: A fetched entry with present clear gives a fault response that carries the virtual page number and allocates no slot, so a repeat of the same request walks memory again.
- R4: A write that hits a dirty cached entry completes with the cached translation and makes no memory access. This holds even when the entry in memory now has present or dirty cleared, so the dirty flag in memory is not set again.
- R5: A write that hits a clean cached entry re-reads the entry from memory. If the fetched entry has present clear, the block answers with a fault and writes nothing to memory.
- R6: In the same clean-hit write case, a fetched entry with present set and writable clear also gives a fault and no memory write.
- R7: A clean-hit write that passes the checks writes the entry back with bit 6 set, and only then answers. The cached copy becomes dirty, so the next write to that page needs no memory access.
- R8: Changes to memory have no effect on a cached entry. A single-page invalidate drops only the matching entry, and a full flush drops every entry.
- R9: Fills take slots in round-robin order over ENTRIES slots, so that after ENTRIES+1 fills into an empty cache the first page filled has been evicted.
- R10: Requests are accepted only when the block is idle. Each accepted request yields exactly one single-cycle response. The response comes 1 cycle after acceptance for a cache-only answer, 3 for a read walk or a fault after fetch, and 4 for a walk with write-back. The memory request holds its address until it is acknowledged.
- R11: A write that misses fetches the entry and faults if it is not present or not writable. Otherwise it writes the entry back with bit 6 set and fills a dirty slot.
- R12: A write that hits a dirty cached entry whose cached writable flag is clear faults at once, with no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_vaddr | input | VA_W | Virtual address of the access |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | PA_W | Translated physical address (zero on fault) |
| rsp_vpn | output | VA_W-12 | Virtual page number of the answered request |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a table write-back, 0 for a fetch |
| mem_addr | output | VA_W-12 | Table word index (the virtual page number) |
| mem_wdata | output | PA_W | Entry word to write back |
| mem_rdata | input | PA_W | Entry word returned by memory, valid with acknowledge |
| mem_ack | input | 1 | Memory access complete |
| inv_one | input | 1 | Drop the cached entry for inv_vpn |
| inv_vpn | input | VA_W-12 | Page to drop |
| inv_all | input | 1 | Drop every cached entry |

## Verification
A request is taken at the clock edge where req_valid meets req_ready. The response strobe appears one edge later for a cache-only answer and three edges later for a fetch that ends in a fill or a fault. It appears four edges later when a write-back follows, because each memory access costs one edge to issue and one to see the acknowledge. The bench model acknowledges half a cycle after it sees a request. The bench drives and samples only on falling edges and counts falling edges from acceptance to the strobe. It checks that count against the expected latency for each case, and it counts memory reads and writes per access to prove which paths touched the table.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int OFF_W  = 12;
  localparam int P_BIT  = 0;
  localparam int W_BIT  = 1;
  localparam int D_BIT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FETCH,
    ST_JUDGE,
    ST_STORE
  } xl_state_e;
endpackage

// File: rtl/xlat_rr.sv
module xlat_rr #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_memport.sv
module xlat_memport #(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (mem_req && mem_ack) begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end else if (start && !mem_req) begin
      mem_req   <= 1'b1;
      mem_we    <= start_we;
      mem_addr  <= start_addr;
      mem_wdata <= start_wdata;
    end
  end

  assign done = mem_req && mem_ack;
endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic               hit_wr,
  output logic               hit_dirty,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               fill_wr,
  input  logic               fill_dirty,
  input  logic               mark_en,
  input  logic [IDX_W-1:0]   mark_idx,
  input  logic               inv_one,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic               inv_all
);
  typedef struct packed {
    logic             vld;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic             wr;
    logic             dirty;
  } slot_t;

  slot_t slots [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_en && fill_idx == IDX_W'(i)) begin
          slots[i] <= '{vld: 1'b1, vpn: fill_vpn, pfn: fill_pfn,
                        wr: fill_wr, dirty: fill_dirty};
        end else begin
          if (mark_en && mark_idx == IDX_W'(i)) slots[i].dirty <= 1'b1;
          if (inv_all || (inv_one && slots[i].vpn == inv_vpn)) slots[i].vld <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = slots[g].vld && (slots[g].vpn == look_vpn);
    assign valid_vec[g] = slots[g].vld;
  end

  always_comb begin
    hit       = 1'b0;
    hit_idx   = '0;
    hit_pfn   = '0;
    hit_wr    = 1'b0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit       = 1'b1;
        hit_idx   = IDX_W'(i);
        hit_pfn   = slots[i].pfn;
        hit_wr    = slots[i].wr;
        hit_dirty = slots[i].dirty;
      end
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [VA_W-1:0]       req_vaddr,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [VA_W-OFF_W-1:0] rsp_vpn,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [VA_W-OFF_W-1:0] mem_addr,
  output logic [PA_W-1:0]       mem_wdata,
  input  logic [PA_W-1:0]       mem_rdata,
  input  logic                  mem_ack,
  input  logic                  inv_one,
  input  logic [VA_W-OFF_W-1:0] inv_vpn,
  input  logic                  inv_all
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [PFN_W-1:0] pte_pfn(input logic [PA_W-1:0] pte);
    return pte[PA_W-1:OFF_W];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  function automatic logic [PA_W-1:0] with_dirty(input logic [PA_W-1:0] pte);
    logic [PA_W-1:0] r;
    r = pte;
    r[D_BIT] = 1'b1;
    return r;
  endfunction

  xl_state_e state, nxt;

  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic             hit_q;
  logic [IDX_W-1:0] slot_q;
  logic [PFN_W-1:0] cpfn_q;
  logic [PA_W-1:0]  pte_q;

  logic               hit, hit_wr, hit_dirty;
  logic [IDX_W-1:0]   hit_idx;
  logic [PFN_W-1:0]   hit_pfn;
  logic [ENTRIES-1:0] match_vec, valid_vec;
  logic [IDX_W-1:0]   rr_ptr;

  logic             start, start_we, mem_done;
  logic [PA_W-1:0]  start_wdata;
  logic             fill_en, fill_wr, fill_dirty, mark_en;
  logic [PFN_W-1:0] fill_pfn;
  logic             rsp_set, flt_set;
  logic [PFN_W-1:0] rsp_set_pfn;
  logic             ev_fast, ev_clean, cap_look, accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_store (
    .clk, .rst_n,
    .look_vpn  (vpn_q),
    .hit, .hit_idx, .hit_pfn, .hit_wr, .hit_dirty,
    .match_vec, .valid_vec,
    .fill_en,
    .fill_idx  (rr_ptr),
    .fill_vpn  (vpn_q),
    .fill_pfn, .fill_wr, .fill_dirty,
    .mark_en,
    .mark_idx  (slot_q),
    .inv_one, .inv_vpn, .inv_all
  );

  xlat_rr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk, .rst_n,
    .adv (fill_en),
    .ptr (rr_ptr)
  );

  xlat_memport #(.AW(VPN_W), .DW(PA_W)) u_port (
    .clk, .rst_n,
    .start, .start_we,
    .start_addr  (vpn_q),
    .start_wdata,
    .done        (mem_done),
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack
  );

  always_comb begin
    nxt         = state;
    start       = 1'b0;
    start_we    = 1'b0;
    start_wdata = with_dirty(pte_q);
    fill_en     = 1'b0;
    fill_pfn    = pte_pfn(pte_q);
    fill_wr     = pte_q[W_BIT];
    fill_dirty  = pte_q[D_BIT];
    mark_en     = 1'b0;
    rsp_set     = 1'b0;
    flt_set     = 1'b0;
    rsp_set_pfn = pte_pfn(pte_q);
    ev_fast     = 1'b0;
    ev_clean    = 1'b0;
    cap_look    = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) nxt = ST_LOOK;
      ST_LOOK: begin
        ev_fast  = hit && wr_q && hit_dirty;
        ev_clean = hit && wr_q && !hit_dirty;
        if (hit && !wr_q) begin
          rsp_set     = 1'b1;
          rsp_set_pfn = hit_pfn;
          nxt         = ST_IDLE;
        end else if (ev_fast) begin
          rsp_set     = 1'b1;
          flt_set     = !hit_wr;
          rsp_set_pfn = hit_pfn;
          nxt         = ST_IDLE;
        end else begin
          start    = 1'b1;
          cap_look = 1'b1;
          nxt      = ST_FETCH;
        end
      end
      ST_FETCH: if (mem_done) nxt = ST_JUDGE;
      ST_JUDGE: begin
        if (!pte_q[P_BIT] || (wr_q && !pte_q[W_BIT])) begin
          rsp_set = 1'b1;
          flt_set = 1'b1;
          nxt     = ST_IDLE;
        end else if (!wr_q) begin
          fill_en = 1'b1;
          rsp_set = 1'b1;
          nxt     = ST_IDLE;
        end else begin
          start    = 1'b1;
          start_we = 1'b1;
          nxt      = ST_STORE;
        end
      end
      ST_STORE: begin
        if (mem_done) begin
          rsp_set = 1'b1;
          nxt     = ST_IDLE;
          if (hit_q) begin
            mark_en     = 1'b1;
            rsp_set_pfn = cpfn_q;
          end else begin
            fill_en    = 1'b1;
            fill_wr    = 1'b1;
            fill_dirty = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      vpn_q     <= '0;
      off_q     <= '0;
      wr_q      <= 1'b0;
      hit_q     <= 1'b0;
      slot_q    <= '0;
      cpfn_q    <= '0;
      pte_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_vpn   <= '0;
    end else begin
      state     <= nxt;
      rsp_valid <= rsp_set;
      if (accept) begin
        vpn_q <= req_vaddr[VA_W-1:OFF_W];
        off_q <= req_vaddr[OFF_W-1:0];
        wr_q  <= req_write;
      end
      if (cap_look) begin
        hit_q  <= hit;
        slot_q <= hit_idx;
        cpfn_q <= hit_pfn;
      end
      if (state == ST_FETCH && mem_done) pte_q <= mem_rdata;
      if (rsp_set) begin
        rsp_fault <= flt_set;
        rsp_paddr <= flt_set ? '0 : join_pa(rsp_set_pfn, off_q);
        rsp_vpn   <= vpn_q;
      end
    end
  end
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ack,
  input logic [VPN_W-1:0]   mem_addr,
  input logic [PA_W-1:0]    mem_wdata,
  input logic               inv_all,
  input logic               fill_en,
  input logic               flt_set,
  input logic               ev_fast,
  input logic               ev_clean,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec
);
  // R2: fills only on a miss, so no page sits in two slots
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  p_no_fill_on_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flt_set |-> !fill_en);

  p_dirty_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fast |=> !mem_req);

  p_clean_hit_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clean |=> (mem_req && !mem_we));

  p_writeback_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[D_BIT]);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fill_en) |=> (valid_vec == '0));

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind xlat_cache xlat_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .inv_all   (inv_all),
  .fill_en   (fill_en),
  .flt_set   (flt_set),
  .ev_fast   (ev_fast),
  .ev_clean  (ev_clean),
  .match_vec (match_vec),
  .valid_vec (valid_vec)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [19:0] rsp_vpn;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        inv_one = 1'b0, inv_all = 1'b0;
  logic [19:0] inv_vpn = '0;

  int total = 0, bad = 0, nrd = 0, nwr = 0;
  bit finished = 0;
  logic [31:0] tbl [32];

  logic        r_fault;
  logic [31:0] r_pa;
  logic [19:0] r_vpn;
  int          r_lat, r_rd, r_wr;

  always #10 clk = ~clk;

  xlat_cache dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_vaddr,
    .rsp_valid, .rsp_fault, .rsp_paddr, .rsp_vpn,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .inv_one, .inv_vpn, .inv_all
  );

  // table memory: acknowledges half a cycle after it sees a request
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        tbl[mem_addr[4:0]] = mem_wdata;
        nwr++;
      end else begin
        mem_rdata = tbl[mem_addr[4:0]];
        nrd++;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  function automatic logic [31:0] entry(input logic [19:0] frame, input bit p,
                                        input bit w, input bit d);
    logic [31:0] e = 32'h0;
    e = e | (32'(frame) << 12);
    if (p) e = e | 32'h1;
    if (w) e = e | 32'h2;
    if (d) e = e | 32'h40;
    return e;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] va);
    int rd0 = nrd;
    int wr0 = nwr;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0;
    while (!rsp_valid && r_lat < 40) begin
      @(negedge clk);
      r_lat++;
    end
    r_fault = rsp_fault;
    r_pa    = rsp_paddr;
    r_vpn   = rsp_vpn;
    r_rd    = nrd - rd0;
    r_wr    = nwr - wr0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10", "ready after reset", 32'(req_ready), 32'd1);
    chk("R10", "no response after reset", 32'(rsp_valid), 32'd0);
    chk("R10", "no memory request after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_read_fill;
    tbl[1] = entry(20'h00ABC, 1, 1, 0);
    access(0, 32'h0000_1234);
    chk("R2", "miss latency", r_lat, 3);
    chk("R2", "miss fetch count", r_rd, 1);
    chk("R1", "miss physical address", r_pa, 32'h00AB_C234);
    chk("R1", "miss fault", 32'(r_fault), 0);
    access(0, 32'h0000_1ABC);
    chk("R2", "hit latency", r_lat, 1);
    chk("R2", "hit fetch count", r_rd, 0);
    chk("R1", "hit physical address", r_pa, 32'h00AB_CABC);
  endtask

  task automatic t_read_absent;
    tbl[2] = entry(20'h00222, 0, 1, 0);
    access(0, 32'h0000_2010);
    chk("R3", "absent fault", 32'(r_fault), 1);
    chk("R3", "absent vpn", 32'(r_vpn), 32'h2);
    chk("R10", "fault-after-fetch latency", r_lat, 3);
    access(0, 32'h0000_2010);
    chk("R3", "no slot: refetch count", r_rd, 1);
    chk("R3", "no slot: still faults", 32'(r_fault), 1);
  endtask

  task automatic t_clean_write_ok;
    access(1, 32'h0000_1008);
    chk("R7", "clean write latency", r_lat, 4);
    chk("R7", "clean write fetch", r_rd, 1);
    chk("R7", "clean write back", r_wr, 1);
    chk("R7", "table dirty bit 6", 32'(tbl[1][6]), 1);
    chk("R7", "table rest intact", tbl[1] & ~32'h40, entry(20'h00ABC, 1, 1, 0));
    chk("R7", "clean write address", r_pa, 32'h00AB_C008);
    access(1, 32'h0000_100C);
    chk("R7", "now-dirty write latency", r_lat, 1);
    chk("R7", "now-dirty write memory use", r_rd + r_wr, 0);
  endtask

  task automatic t_dirty_stale;
    tbl[1] = entry(20'h00ABC, 0, 1, 0);
    access(1, 32'h0000_1FFC);
    chk("R4", "stale dirty write fault", 32'(r_fault), 0);
    chk("R4", "stale dirty write address", r_pa, 32'h00AB_CFFC);
    chk("R4", "stale dirty write memory use", r_rd + r_wr, 0);
    chk("R4", "table dirty not set again", 32'(tbl[1][6]), 0);
    access(0, 32'h0000_1000);
    chk("R8", "stale read still hits", r_lat, 1);
  endtask

  task automatic t_clean_absent;
    tbl[3] = entry(20'h00333, 1, 1, 0);
    access(0, 32'h0000_3000);
    tbl[3] = entry(20'h00333, 0, 1, 0);
    access(1, 32'h0000_3044);
    chk("R5", "clean write on absent fault", 32'(r_fault), 1);
    chk("R5", "clean write refetch", r_rd, 1);
    chk("R5", "no write back", r_wr, 0);
    chk("R5", "fault vpn", 32'(r_vpn), 32'h3);
    chk("R5", "fault latency", r_lat, 3);
    access(0, 32'h0000_3050);
    chk("R8", "cached copy kept latency", r_lat, 1);
    chk("R8", "cached copy kept address", r_pa, 32'h0033_3050);
  endtask

  task automatic t_clean_readonly;
    tbl[4] = entry(20'h00444, 1, 1, 0);
    access(0, 32'h0000_4000);
    tbl[4] = entry(20'h00444, 1, 0, 0);
    access(1, 32'h0000_4004);
    chk("R6", "clean write on read-only fault", 32'(r_fault), 1);
    chk("R6", "refetch", r_rd, 1);
    chk("R6", "no write back", r_wr, 0);
    chk("R6", "table unchanged", tbl[4], entry(20'h00444, 1, 0, 0));
  endtask

  task automatic t_write_miss;
    tbl[5] = entry(20'h00555, 1, 1, 0);
    access(1, 32'h0000_5120);
    chk("R11", "write miss latency", r_lat, 4);
    chk("R11", "write miss address", r_pa, 32'h0055_5120);
    chk("R11", "write miss sets bit 6", tbl[5], entry(20'h00555, 1, 1, 1));
    access(1, 32'h0000_5124);
    chk("R11", "filled dirty: fast write", r_lat, 1);
    tbl[6] = entry(20'h00666, 1, 0, 1);
    access(1, 32'h0000_6000);
    chk("R11", "write miss read-only fault", 32'(r_fault), 1);
    chk("R11", "write miss read-only no write", r_wr, 0);
  endtask

  task automatic t_dirty_readonly;
    tbl[7] = entry(20'h00777, 1, 0, 1);
    access(0, 32'h0000_7000);
    access(1, 32'h0000_7008);
    chk("R12", "cached read-only dirty write fault", 32'(r_fault), 1);
    chk("R12", "latency", r_lat, 1);
    chk("R12", "memory use", r_rd + r_wr, 0);
  endtask

  task automatic t_invalidate;
    @(negedge clk);
    inv_one = 1'b1;
    inv_vpn = 20'h1;
    @(negedge clk);
    inv_one = 1'b0;
    access(0, 32'h0000_1000);
    chk("R8", "dropped page now faults", 32'(r_fault), 1);
    chk("R8", "dropped page fetched", r_rd, 1);
    access(0, 32'h0000_3000);
    chk("R8", "other page kept", r_lat, 1);
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    access(0, 32'h0000_3000);
    chk("R8", "flush: page 3 now faults", 32'(r_fault), 1);
    access(0, 32'h0000_7000);
    chk("R8", "flush: page 7 refetched", r_rd, 1);
  endtask

  task automatic t_round_robin;
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int v = 8; v <= 16; v++) begin
      tbl[v] = entry(20'(32'h100 + v), 1, 1, 0);
      access(0, 32'(v) << 12);
    end
    access(0, 32'h0001_0000);
    chk("R9", "last fill hits", r_lat, 1);
    access(0, 32'h0000_A000);
    chk("R9", "third fill still held", r_lat, 1);
    access(0, 32'h0000_8000);
    chk("R9", "first fill evicted", r_rd, 1);
    chk("R9", "evicted refill address", r_pa, 32'h0010_8000);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) tbl[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_fill();
    t_read_absent();
    t_clean_write_ok();
    t_dirty_stale();
    t_clean_absent();
    t_clean_readonly();
    t_write_miss();
    t_dirty_readonly();
    t_invalidate();
    t_round_robin();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule